// File: doc/BRIEF.md
# Eight-bit multicycle processor datapath

This block is the datapath half of a small multicycle processor that runs a 32-bit instruction format over an 8-bit machine. It holds the program counter, a 32-bit instruction register assembled from four byte loads, an eight-entry register file, the operand holding registers, the ALU with its result register and the register that catches memory read data. An external control state machine drives every multiplexer select and write strobe once per cycle. The datapath returns the opcode, the function field and the ALU zero flag, which that state machine needs to choose its next step.

Memory is reached through one 8-bit address and one 8-bit store bus. Read data comes back on an 8-bit input. Every holding register is overwritten on each clock. A value that the control sequence needs later must therefore be used in the cycle that follows its capture.

Top module: `mcdp_datapath`

## Requirements
- R1: While rst_n is low, every state element clears to zero. After reset, adr, writedata, op and funct all read 0, and with idle selects (operand A from the PC, operand B from register B, aluop 00) zero reads 1.
- R2: Register 0 always reads as 0. A write aimed at register 0 leaves it reading 0.
- R3: The PC loads only in a cycle where pcen is 1. Otherwise it keeps its value.
- R4: When irwrite[k] is 1, memdata is loaded into instruction bits [8k+7:8k] and the other bytes are unchanged. op shows instruction bits [31:26] and funct shows bits [5:0].
- R5: The register fields sit at ra = [25:21], rb = [20:16] and rd = [15:11], and only the low three bits of each select a register. Register A and register B capture the entries named by ra and rb on every clock. writedata shows register B.
- R6: On a clock with regwrite = 1, the register file is written. The target is rb when regdst = 0 and rd when regdst = 1. The data is the ALU result register when memtoreg = 0 and the memory data register (memdata from the previous clock) when memtoreg = 1.
- R7: ALU operand A is the PC when alusrca = 0 and register A when alusrca = 1.
- R8: ALU operand B is selected by alusrcb: 00 gives register B, 01 gives the constant 1, 10 gives instruction bits [7:0], and 11 gives bits [7:0] shifted left by two, truncated to 8 bits.
- R9: aluop 00 adds and aluop 01 subtracts (modulo 256). When aluop[1] is 1, funct picks the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, and 0x2A set-less-than, which gives 1 when A is below B as signed 8-bit values and 0 otherwise. Any other funct adds.
- R10: The next PC is selected by pcsource: 00 gives the live ALU result, 01 gives the ALU result register, 10 gives instruction bits [5:0] followed by two zero bits, and 11 gives the live ALU result.
- R11: adr is the PC when iord = 0 and the ALU result register when iord = 1. The ALU result register captures the ALU output on every clock.
- R12: zero is combinational. It is 1 exactly when the current ALU output is all zeros, including a sum that wraps to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| memdata | input | 8 | Memory read data |
| alusrca | input | 1 | Operand A select |
| alusrcb | input | 2 | Operand B select |
| aluop | input | 2 | ALU operation class |
| pcsource | input | 2 | Next PC select |
| pcen | input | 1 | PC load enable |
| iord | input | 1 | Address select: PC or ALU result register |
| regdst | input | 1 | Write register select: rb or rd |
| memtoreg | input | 1 | Write data select: ALU result register or memory data register |
| regwrite | input | 1 | Register file write enable |
| irwrite | input | 4 | Per-byte instruction register load |
| adr | output | 8 | Memory address |
| writedata | output | 8 | Store data (register B) |
| op | output | 6 | Instruction bits [31:26] |
| funct | output | 6 | Instruction bits [5:0] |
| zero | output | 1 | ALU output is zero |

## Verification
The datapath is driven through short control sequences of the kind a sequencer issues:
- **Byte-wise fetches in scrambled byte order.** These show that each irwrite strobe reaches only its own byte lane.
- **Register loads followed by read-back through register B.** These show the rb/rd target choice and the ALU-result/memory write-data choice.
- **Register fields with high bits set.** These show that only the low three bits index the register file.
- **The five decoded operations on one operand pair.** These distinguish AND from OR and add from subtract.
- **A signed set-less-than with a negative operand.** This tells signed from unsigned comparison.
- **Immediate-shift, jump-target and PC-source sequences.** These expose truncation and select mix-ups.
- **Equal-operand subtraction and a wrapping sum.** These pin down the zero flag.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;

    // ALU operation codes produced by the decoder
    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    // aluop classes
    localparam logic [1:0] AOP_ADD = 2'b00;
    localparam logic [1:0] AOP_SUB = 2'b01;

    // decoded function fields
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    // operand B select
    localparam logic [1:0] SRCB_REG   = 2'b00;
    localparam logic [1:0] SRCB_ONE   = 2'b01;
    localparam logic [1:0] SRCB_IMM   = 2'b10;
    localparam logic [1:0] SRCB_IMMX4 = 2'b11;

    // next PC select
    localparam logic [1:0] PCS_ALU  = 2'b00;
    localparam logic [1:0] PCS_OUT  = 2'b01;
    localparam logic [1:0] PCS_JUMP = 2'b10;

    // instruction field positions
    localparam int OP_LSB = 26;
    localparam int RA_LSB = 21;
    localparam int RB_LSB = 16;
    localparam int RD_LSB = 11;
    localparam int FN_W   = 6;

endpackage

// File: rtl/mcdp_aluctl.sv
module mcdp_aluctl
    import mcdp_pkg::*;
(
    input  logic [1:0]      aluop,
    input  logic [FN_W-1:0] funct,
    output alu_op_e         op_sel
);

    always_comb begin
        op_sel = ALU_ADD;
        if (aluop[1]) begin
            unique case (funct)
                FN_SUB:  op_sel = ALU_SUB;
                FN_AND:  op_sel = ALU_AND;
                FN_OR:   op_sel = ALU_OR;
                FN_SLT:  op_sel = ALU_SLT;
                default: op_sel = ALU_ADD;
            endcase
        end else if (aluop == AOP_SUB) begin
            op_sel = ALU_SUB;
        end
    end

endmodule

// File: rtl/mcdp_alu.sv
module mcdp_alu
    import mcdp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op_sel,
    output logic [W-1:0] y
);

    logic [W-1:0] diff;
    logic         lt;

    assign diff = a - b;
    assign lt   = ($signed(a) < $signed(b));

    always_comb begin
        unique case (op_sel)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SUB: y = diff;
            ALU_SLT: y = {{(W-1){1'b0}}, lt};
            default: y = a + b;
        endcase
    end

endmodule

// File: rtl/mcdp_regfile.sv
module mcdp_regfile #(
    parameter int W    = 8,
    parameter int NREG = 8,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_idx,
    input  logic [AW-1:0] rb_idx,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b
);

    logic [W-1:0] regs_d [NREG];
    logic [W-1:0] regs_q [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) regs_d[i] = regs_q[i];
        if (we && (wa != '0)) regs_d[wa] = wd;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NREG; gi++) begin : g_ent
            if (gi == 0) begin : g_zero
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) regs_q[gi] <= '0;
                    else        regs_q[gi] <= '0;
                end
            end else begin : g_store
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) regs_q[gi] <= '0;
                    else        regs_q[gi] <= regs_d[gi];
                end
            end
        end
    endgenerate

    assign rd_a = (ra_idx == '0) ? '0 : regs_q[ra_idx];
    assign rd_b = (rb_idx == '0) ? '0 : regs_q[rb_idx];

endmodule

// File: rtl/mcdp_datapath.sv
module mcdp_datapath
    import mcdp_pkg::*;
#(
    parameter int W    = 8,
    parameter int IRW  = 32,
    parameter int NREG = 8,
    localparam int NB  = IRW / W,
    localparam int RIW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W-1:0]    memdata,
    input  logic            alusrca,
    input  logic [1:0]      alusrcb,
    input  logic [1:0]      aluop,
    input  logic [1:0]      pcsource,
    input  logic            pcen,
    input  logic            iord,
    input  logic            regdst,
    input  logic            memtoreg,
    input  logic            regwrite,
    input  logic [NB-1:0]   irwrite,
    output logic [W-1:0]    adr,
    output logic [W-1:0]    writedata,
    output logic [5:0]      op,
    output logic [FN_W-1:0] funct,
    output logic            zero
);

    typedef struct packed {
        logic [W-1:0]   pc;
        logic [IRW-1:0] ir;
        logic [W-1:0]   a;
        logic [W-1:0]   b;
        logic [W-1:0]   aluout;
        logic [W-1:0]   mdr;
    } dp_t;

    dp_t st_d, st_q;

    logic [W-1:0]   rf_a, rf_b;
    logic [W-1:0]   src_a, src_b, alu_y, imm, wr_data;
    logic [RIW-1:0] ra_idx, rb_idx, rd_idx, wr_idx;
    alu_op_e        op_sel;

    // field extraction
    assign ra_idx = st_q.ir[RA_LSB +: RIW];
    assign rb_idx = st_q.ir[RB_LSB +: RIW];
    assign rd_idx = st_q.ir[RD_LSB +: RIW];
    assign imm    = st_q.ir[W-1:0];

    assign wr_idx  = regdst   ? rd_idx   : rb_idx;
    assign wr_data = memtoreg ? st_q.mdr : st_q.aluout;

    mcdp_regfile #(.W(W), .NREG(NREG)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_idx (ra_idx),
        .rb_idx (rb_idx),
        .we     (regwrite),
        .wa     (wr_idx),
        .wd     (wr_data),
        .rd_a   (rf_a),
        .rd_b   (rf_b)
    );

    // operand selection
    always_comb begin
        src_a = alusrca ? st_q.a : st_q.pc;
        unique case (alusrcb)
            SRCB_REG:   src_b = st_q.b;
            SRCB_ONE:   src_b = W'(1);
            SRCB_IMM:   src_b = imm;
            default:    src_b = {imm[W-3:0], 2'b00};
        endcase
    end

    mcdp_aluctl u_ctl (
        .aluop  (aluop),
        .funct  (st_q.ir[FN_W-1:0]),
        .op_sel (op_sel)
    );

    mcdp_alu #(.W(W)) u_alu (
        .a      (src_a),
        .b      (src_b),
        .op_sel (op_sel),
        .y      (alu_y)
    );

    // next state
    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NB; k++) begin
            if (irwrite[k]) st_d.ir[k*W +: W] = memdata;
        end
        st_d.mdr    = memdata;
        st_d.a      = rf_a;
        st_d.b      = rf_b;
        st_d.aluout = alu_y;
        if (pcen) begin
            unique case (pcsource)
                PCS_OUT:  st_d.pc = st_q.aluout;
                PCS_JUMP: st_d.pc = W'({st_q.ir[5:0], 2'b00});
                default:  st_d.pc = alu_y;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign adr       = iord ? st_q.aluout : st_q.pc;
    assign writedata = st_q.b;
    assign op        = st_q.ir[OP_LSB +: 6];
    assign funct     = st_q.ir[FN_W-1:0];
    assign zero      = (alu_y == '0);

endmodule

// File: rtl/mcdp_datapath_chk.sv
module mcdp_datapath_chk #(
    parameter int W   = 8,
    parameter int IRW = 32,
    localparam int NB = IRW / W
) (
    input logic           clk,
    input logic           rst_n,
    input logic           pcen,
    input logic [1:0]     pcsource,
    input logic [NB-1:0]  irwrite,
    input logic [W-1:0]   memdata,
    input logic           zero,
    input logic [W-1:0]   pc,
    input logic [IRW-1:0] ir,
    input logic [W-1:0]   aluout
);

    // R3: PC holds without pcen
    a_r3_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pcen |=> $stable(pc));

    // R10: jump target formed from the low instruction bits
    a_r10_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        (pcen && pcsource == 2'b10) |=> pc == W'({$past(ir[5:0]), 2'b00}));

    // R4: no strobe, no change to the instruction register
    a_r4_ir_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (irwrite == '0) |=> $stable(ir));

    // R12: a zero flag means the captured ALU result is zero
    a_r12_zero_capture: assert property (@(posedge clk) disable iff (!rst_n)
        zero |=> (aluout == '0));

    genvar gk;
    generate
        for (gk = 0; gk < NB; gk++) begin : g_byte
            // R4: strobed byte lane takes memdata
            a_r4_ir_byte: assert property (@(posedge clk) disable iff (!rst_n)
                irwrite[gk] |=> ir[gk*W +: W] == $past(memdata));
        end
    endgenerate

endmodule

bind mcdp_datapath mcdp_datapath_chk #(.W(W), .IRW(IRW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pcen     (pcen),
    .pcsource (pcsource),
    .irwrite  (irwrite),
    .memdata  (memdata),
    .zero     (zero),
    .pc       (st_q.pc),
    .ir       (st_q.ir),
    .aluout   (st_q.aluout)
);

// File: tb/mcdp_datapath_tb.sv
module mcdp_datapath_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] memdata = '0;
    logic       alusrca = 1'b0;
    logic [1:0] alusrcb = '0, aluop = '0, pcsource = '0;
    logic       pcen = 1'b0, iord = 1'b0, regdst = 1'b0, memtoreg = 1'b0, regwrite = 1'b0;
    logic [3:0] irwrite = '0;
    logic [7:0] adr, writedata;
    logic [5:0] op, funct;
    logic       zero;

    always #10 clk = ~clk;

    mcdp_datapath u_dut (
        .clk(clk), .rst_n(rst_n), .memdata(memdata), .alusrca(alusrca),
        .alusrcb(alusrcb), .aluop(aluop), .pcsource(pcsource), .pcen(pcen),
        .iord(iord), .regdst(regdst), .memtoreg(memtoreg), .regwrite(regwrite),
        .irwrite(irwrite), .adr(adr), .writedata(writedata), .op(op),
        .funct(funct), .zero(zero)
    );

    typedef struct {
        logic [7:0] adr;
        logic [7:0] wd;
        logic [5:0] op;
        logic [5:0] fn;
        logic       z;
        string      tag;
    } exp_t;

    exp_t  q[$];
    int    n_chk = 0, n_fail = 0;
    string cur_tag = "R1";
    bit    done = 1'b0;

    // bench model state
    logic [7:0]  m_pc = '0, m_a = '0, m_b = '0, m_out = '0, m_mdr = '0;
    logic [31:0] m_ir = '0;
    logic [7:0]  m_rf [8];

    function automatic logic [7:0] model_alu(logic [7:0] x, logic [7:0] y,
                                             logic [1:0] ao, logic [5:0] fn);
        if (ao == 2'b00) return x + y;
        if (ao == 2'b01) return x - y;
        case (fn)
            6'h22:   return x - y;
            6'h24:   return x & y;
            6'h25:   return x | y;
            6'h2A:   return ($signed(x) < $signed(y)) ? 8'd1 : 8'd0;
            default: return x + y;
        endcase
    endfunction

    // driver: push expectation for this cycle, then advance the model
    task automatic tick();
        exp_t e;
        logic [7:0] sa, sb, res, n_pc;
        logic [2:0] wi;
        logic [31:0] n_ir;
        sa = alusrca ? m_a : m_pc;
        case (alusrcb)
            2'b00:   sb = m_b;
            2'b01:   sb = 8'd1;
            2'b10:   sb = m_ir[7:0];
            default: sb = {m_ir[5:0], 2'b00};
        endcase
        res = model_alu(sa, sb, aluop, m_ir[5:0]);
        e.adr = iord ? m_out : m_pc;
        e.wd  = m_b;
        e.op  = m_ir[31:26];
        e.fn  = m_ir[5:0];
        e.z   = (res == 8'd0);
        e.tag = cur_tag;
        q.push_back(e);
        n_pc = m_pc;
        if (pcen) begin
            case (pcsource)
                2'b01:   n_pc = m_out;
                2'b10:   n_pc = {m_ir[5:0], 2'b00};
                default: n_pc = res;
            endcase
        end
        n_ir = m_ir;
        for (int k = 0; k < 4; k++) if (irwrite[k]) n_ir[k*8 +: 8] = memdata;
        @(posedge clk);
        #1;
        wi = regdst ? m_ir[13:11] : m_ir[18:16];
        m_a = m_rf[m_ir[23:21]];
        m_b = m_rf[m_ir[18:16]];
        if (regwrite && wi != 3'd0) m_rf[wi] = memtoreg ? m_mdr : m_out;
        m_out = res;
        m_mdr = memdata;
        m_pc  = n_pc;
        m_ir  = n_ir;
        pcen = 1'b0; regwrite = 1'b0; irwrite = '0; iord = 1'b0;
    endtask

    // monitor: compare away from the active edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (adr !== e.adr || writedata !== e.wd || op !== e.op ||
                funct !== e.fn || zero !== e.z) begin
                n_fail++;
                $display("FAIL %s: adr=%h/%h wd=%h/%h op=%h/%h funct=%h/%h zero=%b/%b (actual/expected)",
                         e.tag, adr, e.adr, writedata, e.wd, op, e.op, funct, e.fn, zero, e.z);
            end
        end
    end

    function automatic logic [31:0] mk_r(logic [4:0] ra, logic [4:0] rb, logic [4:0] rd, logic [5:0] fn);
        return {6'd0, ra, rb, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] mk_i(logic [5:0] o, logic [4:0] ra, logic [4:0] rb, logic [15:0] im);
        return {o, ra, rb, im};
    endfunction

    // fetch in scrambled lane order 2,0,3,1
    task automatic load_ir(logic [31:0] w);
        int ord [4] = '{2, 0, 3, 1};
        foreach (ord[i]) begin
            irwrite = 4'b0001 << ord[i];
            memdata = w[ord[i]*8 +: 8];
            tick();
        end
    endtask

    task automatic set_reg(logic [4:0] r, logic [7:0] v);
        load_ir(mk_i(6'h08, 5'd0, r, 16'h0000));
        memdata = v; tick();
        regwrite = 1'b1; memtoreg = 1'b1; regdst = 1'b0; tick();
        memtoreg = 1'b0;
    endtask

    // R-type op on (ra, rb), result written to rd, then shown on adr
    task automatic run_r(logic [4:0] ra, logic [4:0] rb, logic [4:0] rd, logic [5:0] fn, logic [1:0] ao);
        load_ir(mk_r(ra, rb, rd, fn));
        tick();
        alusrca = 1'b1; alusrcb = 2'b00; aluop = ao; tick();
        iord = 1'b1; regwrite = 1'b1; regdst = 1'b1; memtoreg = 1'b0; tick();
        alusrca = 1'b0; aluop = 2'b00; regdst = 1'b0;
        tick();
    endtask

    initial begin : wdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : drv
        for (int i = 0; i < 8; i++) m_rf[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        cur_tag = "R1"; tick();

        // PC increments through the ALU, then holds
        cur_tag = "R10";
        for (int i = 0; i < 3; i++) begin
            alusrcb = 2'b01; pcsource = 2'b00; pcen = 1'b1; tick();
        end
        cur_tag = "R3";
        tick(); memdata = 8'h3C; tick();

        // byte-lane loading and field outputs
        cur_tag = "R4";
        load_ir(32'hA5C3_1E2F);
        memdata = 8'hFF; tick(); tick();

        cur_tag = "R6";
        set_reg(5'd1, 8'h05);
        set_reg(5'd2, 8'h03);
        set_reg(5'd3, 8'h80);
        set_reg(5'd4, 8'hF0);
        set_reg(5'd7, 8'h7F);

        // write to register 0 ignored, reads 0
        cur_tag = "R2";
        set_reg(5'd0, 8'h55);
        tick(); tick();

        // index by low 3 bits: rb=9 -> 1, ra=10 -> 2
        cur_tag = "R5";
        load_ir(mk_i(6'h08, 5'd10, 5'd9, 16'h0000));
        tick(); tick();
        cur_tag = "R7";
        alusrca = 1'b1; alusrcb = 2'b00; tick();
        cur_tag = "R11";
        alusrca = 1'b0; iord = 1'b1; tick();
        tick();

        // decoded operations and ALU-result write-back to rd
        cur_tag = "R9";
        run_r(5'd1, 5'd2, 5'd5, 6'h20, 2'b10);
        run_r(5'd1, 5'd2, 5'd5, 6'h22, 2'b10);
        run_r(5'd1, 5'd2, 5'd5, 6'h24, 2'b10);
        run_r(5'd1, 5'd2, 5'd5, 6'h25, 2'b11);
        run_r(5'd3, 5'd1, 5'd5, 6'h2A, 2'b10);
        run_r(5'd1, 5'd3, 5'd6, 6'h2A, 2'b10);
        run_r(5'd7, 5'd1, 5'd6, 6'h3F, 2'b10);
        run_r(5'd1, 5'd2, 5'd6, 6'h20, 2'b01);
        cur_tag = "R6";
        load_ir(mk_i(6'h08, 5'd0, 5'd5, 16'h0000)); tick(); tick();
        load_ir(mk_i(6'h08, 5'd0, 5'd6, 16'h0000)); tick(); tick();

        // zero flag: equal subtract and wrapping add
        cur_tag = "R12";
        run_r(5'd2, 5'd2, 5'd6, 6'h00, 2'b01);
        load_ir(mk_i(6'h08, 5'd4, 5'd0, 16'h0010));
        tick();
        alusrca = 1'b1; alusrcb = 2'b10; aluop = 2'b00; tick();
        alusrca = 1'b0; alusrcb = 2'b00; tick();

        // immediate operand forms and next-PC sources
        cur_tag = "R8";
        load_ir(mk_i(6'h23, 5'd0, 5'd0, 16'h12C7));
        alusrcb = 2'b10; tick();
        alusrcb = 2'b11; tick();
        cur_tag = "R10";
        alusrcb = 2'b00; pcsource = 2'b01; pcen = 1'b1; tick();
        tick();
        pcsource = 2'b10; pcen = 1'b1; tick();
        tick();
        alusrcb = 2'b10; pcsource = 2'b11; pcen = 1'b1; tick();
        alusrcb = 2'b00; pcsource = 2'b00; tick();
        cur_tag = "R11";
        iord = 1'b1; tick();
        tick();

        @(negedge clk); @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule